// File: doc/BRIEF.md
# Fractional UART Baud Clock Generator

This block produces the timing enables that a UART's shift logic uses for receiving and transmitting. It runs entirely in the core clock domain. A power-of-two prescaler is set by a 3-bit exponent. A fractional stage after it divides by (1 + N/64), with N a 6-bit value, and a phase accumulator does this division. A fixed divide by 2 then gives a sampling enable at 16 times the bit rate, and a divide by 16 gives one tick per bit. The resulting bit rate is 2·f_core / (2^E · (N + 64)). The fractional stage lets awkward crystal frequencies reach standard rates with sub-percent error. For example, a 11.0592 MHz core clock with E = 1 and N = 0x20 gives exactly 115200 bit/s.

Two byte-wide registers are loaded through a simple write port. The control register holds a generator-select flag and the exponent. The fraction register holds N. When the flag is clear, the rx and tx enables come from a legacy timer source that enters as inputs, and they pass through unchanged. Any register write restarts every divider stage, so that a new rate starts from a clean phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset both registers read as zero in effect: the generator is deselected, bit_tick is low, and rx_clk_en/tx_clk_en follow the legacy inputs.
- R2: With wr_sel = 0 a write loads the control register: bit 7 is the generator-select flag and bits 2:0 are the exponent E, and bits 6:3 have no effect. With wr_sel = 1 a write loads N from bits 5:0, and bits 7:6 have no effect.
- R3: While the generator is selected, every two consecutive bit_tick intervals last exactly 2^E·(64+N) core cycles together.
- R4: While the generator is selected, rx_clk_en and tx_clk_en are identical. They pulse exactly 16 times per bit_tick interval, and every bit_tick coincides with one of these pulses.
- R5: Each single bit_tick interval is either floor((64+N)/2)·2^E or ceil((64+N)/2)·2^E cycles.
- R6: While the generator is deselected, rx_clk_en and tx_clk_en equal legacy_rx_en and legacy_tx_en one cycle later, and bit_tick stays low.
- R7: A write restarts all stages. The first bit_tick after it appears exactly ceil((64+N)/2)·2^E cycles after the clock edge that takes the write, and none appears in the two cycles after that edge.
- R8: Exponents 6 and 7 are legal and extend the prescaler to 64 and 128.
- R9: All outputs are single-cycle enables, and bit_tick is never high in two consecutive cycles.
- R10: E = 1 with N = 0x20 gives a 96-cycle bit period (exactly 115200 bit/s at 11.0592 MHz). E = 1 with N = 0x28 gives a 104-cycle bit period (115384.6 bit/s at 12 MHz, +0.16%).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 selects the fraction register |
| wr_data | input | 8 | Write data |
| legacy_rx_en | input | 1 | Receive enable from the legacy timer source |
| legacy_tx_en | input | 1 | Transmit enable from the legacy timer source |
| rx_clk_en | output | 1 | Receive clock enable, at 16x the bit rate |
| tx_clk_en | output | 1 | Transmit clock enable, at 16x the bit rate |
| bit_tick | output | 1 | One pulse per bit period |

## Verification
All outputs are registered. A legacy input therefore appears on rx_clk_en/tx_clk_en one cycle after it is driven. After a write, the first bit tick is due exactly ceil((64+N)/2)·2^E cycles after the edge that takes the write. Later ticks follow at the intervals set by R3 and R5. The bench drives inputs on falling edges and counts falling edges from the write edge, so each expected cycle number is compared against an exact count rather than a window. Rate checks cover an even number of bit intervals, because the accumulator phase repeats over that span and the expected cycle total is then an integer with no rounding.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  localparam int REG_W      = 8;
  localparam int EXP_W      = 3;
  localparam int FRAC_W     = 6;
  localparam int SEL_BIT    = 7;
  localparam int PRE_DIV    = 2;
  localparam int OVERSAMPLE = 16;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_FRAC = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import frac_baud_pkg::*;
#(
  parameter int EXP_W  = frac_baud_pkg::EXP_W,
  parameter int FRAC_W = frac_baud_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic              gen_en,
  output logic [EXP_W-1:0]  exp_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[SEL_BIT-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_en <= 1'b0;
      exp_q  <= '0;
      frac_q <= '0;
    end else if (wr_en) begin
      if (reg_sel_e'(wr_sel) == SEL_CTRL) begin
        gen_en <= wr_data[SEL_BIT];
        exp_q  <= wr_data[EXP_W-1:0];
      end else begin
        frac_q <= wr_data[FRAC_W-1:0];
      end
    end
  end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [EXP_W-1:0] exp_q,
  output logic             pre_tick
);
  localparam int CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;

  assign span     = {{CNT_W{1'b0}}, 1'b1} << exp_q;
  assign limit    = span[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
  assign pre_tick = !clr && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt <= '0;
    else if (pre_tick) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/baud_frac.sv
module baud_frac #(
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac_q,
  output logic              pulse
);
  localparam int ONE   = 1 << FRAC_W;
  localparam int ACC_W = FRAC_W + 1;
  localparam int SUM_W = FRAC_W + 2;

  logic [ACC_W-1:0] acc;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] thr;
  logic [SUM_W-1:0] rem;

  assign sum   = {1'b0, acc} + SUM_W'(ONE);
  assign thr   = SUM_W'(ONE) + {2'b00, frac_q};
  assign rem   = sum - thr;
  assign pulse = step && (sum >= thr);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (step)  acc <= pulse ? rem[ACC_W-1:0] : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/baud_modcnt.sv
module baud_modcnt #(
  parameter int MOD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic wrap
);
  generate
    if (MOD <= 1) begin : g_pass
      assign wrap = step;
    end else begin : g_count
      localparam int CW = $clog2(MOD);
      logic [CW-1:0] cnt;
      assign wrap = step && (cnt == CW'(MOD - 1));
      always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (wrap)  cnt <= '0;
        else if (step)  cnt <= cnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int EXP_W  = 3,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              legacy_rx_en,
  input logic              legacy_tx_en,
  input logic              rx_clk_en,
  input logic              tx_clk_en,
  input logic              bit_tick,
  input logic              gen_en,
  input logic [EXP_W-1:0]  exp_q,
  input logic [FRAC_W-1:0] frac_q
);
  localparam int ONE   = 1 << FRAC_W;
  localparam int GAP_W = 20;

  logic [GAP_W-1:0] gap, lo, hi;
  logic             gap_ok, wr_q;

  assign lo = GAP_W'((ONE + int'(frac_q)) >> 1) << exp_q;
  assign hi = GAP_W'((ONE + int'(frac_q) + 1) >> 1) << exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap <= '0; gap_ok <= 1'b0; wr_q <= 1'b0;
    end else begin
      wr_q <= wr_en;
      if (bit_tick && !wr_q) begin
        gap <= GAP_W'(1); gap_ok <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
      if (wr_en) gap_ok <= 1'b0;
    end
  end

  AST_LEGACY_RX: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> (rx_clk_en == $past(legacy_rx_en))); // R6
  AST_LEGACY_TX: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> (tx_clk_en == $past(legacy_tx_en))); // R6
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> !bit_tick); // R6
  AST_RXTX_MATCH: assert property (@(posedge clk) disable iff (rst)
    gen_en |=> (rx_clk_en == tx_clk_en)); // R4
  AST_TICK_ON_X16: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> rx_clk_en); // R4
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R9
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !bit_tick ##1 !bit_tick); // R7
  AST_GAP_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && gap_ok && !wr_q) |-> (gap >= lo && gap <= hi)); // R5
endmodule

bind frac_baud_gen frac_baud_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en),
  .legacy_rx_en(legacy_rx_en), .legacy_tx_en(legacy_tx_en),
  .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en), .bit_tick(bit_tick),
  .gen_en(gen_en), .exp_q(exp_q), .frac_q(frac_q)
);

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int EXP_W      = frac_baud_pkg::EXP_W,
  parameter int FRAC_W     = frac_baud_pkg::FRAC_W,
  parameter int PRE_DIV    = frac_baud_pkg::PRE_DIV,
  parameter int OVERSAMPLE = frac_baud_pkg::OVERSAMPLE
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       legacy_rx_en,
  input  logic       legacy_tx_en,
  output logic       rx_clk_en,
  output logic       tx_clk_en,
  output logic       bit_tick
);
  logic              gen_en;
  logic [EXP_W-1:0]  exp_q;
  logic [FRAC_W-1:0] frac_q;
  logic              clr, pre_tick, frac_pulse, x16_en, bit_en;

  assign clr = wr_en || !gen_en;

  baud_regs #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .gen_en(gen_en), .exp_q(exp_q), .frac_q(frac_q)
  );

  baud_prescale #(.EXP_W(EXP_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr), .exp_q(exp_q), .pre_tick(pre_tick)
  );

  baud_frac #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst(rst), .clr(clr), .step(pre_tick), .frac_q(frac_q),
    .pulse(frac_pulse)
  );

  baud_modcnt #(.MOD(PRE_DIV)) u_half (
    .clk(clk), .rst(rst), .clr(clr), .step(frac_pulse), .wrap(x16_en)
  );

  baud_modcnt #(.MOD(OVERSAMPLE)) u_os (
    .clk(clk), .rst(rst), .clr(clr), .step(x16_en), .wrap(bit_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_clk_en <= 1'b0;
      tx_clk_en <= 1'b0;
      bit_tick  <= 1'b0;
    end else begin
      rx_clk_en <= gen_en ? x16_en : legacy_rx_en;
      tx_clk_en <= gen_en ? x16_en : legacy_tx_en;
      bit_tick  <= gen_en && bit_en;
    end
  end
endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;
  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic       legacy_rx_en = 1'b0, legacy_tx_en = 1'b0;
  logic       rx_clk_en, tx_clk_en, bit_tick;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .legacy_rx_en(legacy_rx_en), .legacy_tx_en(legacy_tx_en),
    .rx_clk_en(rx_clk_en), .tx_clk_en(tx_clk_en), .bit_tick(bit_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_gap(int e, int f);
    return ((64 + f + 1) / 2) << e;
  endfunction

  function automatic int pair_span(int e, int f, int m);
    return (m * (64 + f)) << e;
  endfunction

  // Drive at a falling edge; return at the falling edge after the taking edge.
  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Call right after the final write; m = number of bit-interval pairs.
  task automatic run_rate(input int e, input int f, input int m, output int span);
    int n = 0, n0, prev, ticks = 0, rxc = 0, lo, hi;
    bit split = 0, gapbad = 0, misalign = 0;
    while (!bit_tick && n < 60000) begin @(negedge clk); n++; end
    check(n == first_gap(e, f), "R7", "first tick after write", n, first_gap(e, f));
    n0 = n; prev = n;
    lo = ((64 + f) / 2) << e;
    hi = ((64 + f + 1) / 2) << e;
    while (ticks < 2 * m && (n - n0) < 200000) begin
      @(negedge clk); n++;
      if (rx_clk_en != tx_clk_en) split = 1;
      if (rx_clk_en) rxc++;
      if (bit_tick) begin
        if ((n - prev) < lo || (n - prev) > hi) gapbad = 1;
        if (!rx_clk_en) misalign = 1;
        prev = n; ticks++;
      end
    end
    span = n - n0;
    check(span == pair_span(e, f, m), "R3", "cycles over even bit count", span, pair_span(e, f, m));
    check(rxc == 32 * m, "R4", "x16 pulses over span", rxc, 32 * m);
    check(!split && !misalign, "R4", "rx/tx equal and tick aligned", split | misalign, 0);
    check(!gapbad, "R5", "single interval floor/ceil", gapbad, 0);
  endtask

  task automatic setup_and_run(input int e, input int f, input int m, output int span);
    wr(1'b1, 8'(f));
    wr(1'b0, 8'h80 | 8'(e));
    run_rate(e, f, m, span);
  endtask

  initial begin
    int span, seed, e, f;
    seed = $urandom(32'd5021);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!rx_clk_en && !tx_clk_en && !bit_tick, "R1", "outputs after reset",
          {rx_clk_en, tx_clk_en, bit_tick}, 0);
    legacy_rx_en = 1'b1; legacy_tx_en = 1'b0;
    @(negedge clk);
    check(rx_clk_en == 1'b1 && tx_clk_en == 1'b0, "R1", "legacy path selected at reset",
          {rx_clk_en, tx_clk_en}, 2);
    legacy_rx_en = 1'b0;

    // R2 / R10: ignored bits set, expect E=1 N=0x20 -> 96-cycle bit
    wr(1'b1, 8'hE0);
    wr(1'b0, 8'hF9);
    run_rate(1, 32, 2, span);
    check(span / 4 == 96, "R10", "bit period E=1 N=0x20", span / 4, 96);
    check(span == pair_span(1, 32, 2), "R2", "ignored register bits", span, pair_span(1, 32, 2));

    setup_and_run(1, 40, 2, span);
    check(span / 4 == 104, "R10", "bit period E=1 N=0x28", span / 4, 104);

    setup_and_run(0, 0, 2, span);
    setup_and_run(0, 63, 2, span);
    setup_and_run(7, 63, 1, span);
    check(span == 16256, "R8", "exponent 7 prescale", span, 16256);
    setup_and_run(6, 1, 1, span);
    check(span == 4160, "R8", "exponent 6 prescale", span, 4160);

    for (int i = 0; i < 6; i++) begin
      e = $urandom_range(0, 4);
      f = $urandom_range(0, 63);
      setup_and_run(e, f, 3, span);
    end

    // R7: rewrite mid-run restarts phase
    wr(1'b1, 8'd10);
    wr(1'b0, 8'h82);
    repeat (37) @(negedge clk);
    wr(1'b1, 8'd10);
    run_rate(2, 10, 1, span);

    // R6: deselect, legacy passes with one-cycle latency
    wr(1'b0, 8'h03);
    for (int i = 0; i < 12; i++) begin
      logic lr, lt;
      lr = 1'($urandom); lt = 1'($urandom);
      legacy_rx_en = lr; legacy_tx_en = lt;
      @(negedge clk);
      check(rx_clk_en == lr && tx_clk_en == lt && !bit_tick, "R6", "legacy pass-through",
            {rx_clk_en, tx_clk_en, bit_tick}, {lr, lt, 1'b0});
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule